// File: doc/BRIEF.md
# E1 National Bit Data Link

This block sits beside an E1 framer and handles the five national bits Sa4 to Sa8. These bits ride in timeslot zero of every odd-numbered frame, the frame that does not carry the alignment word. The framer supplies the serial bit stream together with a sync strobe. The strobe marks bit 1 of timeslot zero and says which frame type starts there.

On transmit, each of the five bit positions is filled from its own source: a processor register, a bit stream from an HDLC serializer, an external serial data link pin, or a transparent backplane stream. Every other bit passes through with one cycle of delay. The sources can be mixed freely, so one frame can carry Sa4 from the register and Sa7 from the pin. The processor register is sampled once per frame, so a write that arrives in the middle of a frame can never be split across the bits.

On receive, the five bits always go to a readable register. They are also sent out serially on a data link pin with a gating clock. A bit whose received value differs from the previous odd frame sets a sticky change flag. Any unmasked flag raises the interrupt. Between sync strobes the block keeps counting bit positions and alternates the frame type on its own.

Top module: `e1_sa_link`

## Requirements
- R1: Outside the Sa bit times (all of the even frames, and bits 1 to 3 and all later bits of the odd frames), `tx_out` equals `tx_in` delayed by one clock.
- R2: Sa bit k (k = 0 for Sa4 through k = 4 for Sa8, which is bit 4+k of timeslot zero, zero-based clock position 3+k after the sync strobe) takes its source from field `sa_src[2k+1:2k]`: 0 means register, 1 means HDLC, 2 means pin, 3 means backplane. Each field acts independently of the others. The inserted value appears on `tx_out` one clock after its bit time.
- R3: The register source uses `tx_sa_reg[k]` as sampled in the bit-1 clock of the odd frame. Changes made later in that frame do not affect it.
- R4: For HDLC-sourced positions with `hdlc_path_sel` = 0, `hdlc_tx_req` is high during that bit time and `hdlc_tx_bit` is inserted. With `hdlc_path_sel` = 1, `hdlc_tx_req` stays low and `tx_in` passes through.
- R5: `dl_tx_clk` is high exactly during pin-sourced Sa bit times, and `dl_tx_data` sampled in those cycles is inserted.
- R6: For backplane-sourced positions, `bp_tx_bit` is inserted.
- R7: `rx_sa[k]` holds received Sa bit k of the latest complete odd frame. It updates one clock after Sa8 has been received, whatever the transmit settings are.
- R8: `dl_rx_clk` is high, and `dl_rx_data` carries the received bit, one clock after each of the five received Sa bit times. At all other times both are low.
- R9: `sa_latched[k]` sets when received Sa bit k differs from its value in the previous odd frame; the first odd frame after reset never sets it. A `stat_rd` pulse clears all the flags, and a new change in the same clock still sets its flag.
- R10: `irq` is high exactly when some `sa_latched[k]` is set while `irq_mask[k]` = 0.
- R11: With no sync strobe, bit positions keep counting modulo 256 and the frame type alternates every frame.
- R12: After reset, `tx_out`, `dl_tx_clk`, `hdlc_tx_req`, `dl_rx_clk`, `dl_rx_data`, `rx_sa`, `sa_latched` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_sync | input | 1 | Transmit: bit 1 of timeslot zero is present |
| tx_nfas | input | 1 | Transmit: frame starting at tx_sync is an odd frame |
| tx_in | input | 1 | Transmit serial stream from the framer |
| tx_out | output | 1 | Transmit stream with Sa bits inserted |
| sa_src | input | 10 | Per-Sa-bit source select, 2 bits each |
| hdlc_path_sel | input | 1 | 0 lets the HDLC source be used |
| tx_sa_reg | input | 5 | Processor transmit Sa value |
| hdlc_tx_bit | input | 1 | HDLC serializer bit |
| hdlc_tx_req | output | 1 | HDLC bit is taken this clock |
| dl_tx_data | input | 1 | External transmit data link bit |
| dl_tx_clk | output | 1 | Transmit data link sample clock |
| bp_tx_bit | input | 1 | Backplane timeslot zero bit |
| rx_sync | input | 1 | Receive: bit 1 of timeslot zero is present |
| rx_nfas | input | 1 | Receive: frame is an odd frame |
| rx_in | input | 1 | Receive serial stream |
| rx_sa | output | 5 | Received Sa bits |
| sa_latched | output | 5 | Sticky per-bit change flags |
| stat_rd | input | 1 | Read strobe that clears sa_latched |
| irq_mask | input | 5 | 1 blocks the matching flag from irq |
| irq | output | 1 | Interrupt |
| dl_rx_clk | output | 1 | Receive data link gating clock |
| dl_rx_data | output | 1 | Receive data link bit |

## Verification
The hardest case to reach from the ports is a frame that mixes all four sources while a register write lands inside the same frame. The stimulus draws a fresh random source field for every Sa position in each odd frame. It also rewrites `tx_sa_reg` two clocks after the sync strobe, so any late sampling of the register shows up as a wrong bit. A second hard case is a change event and a clearing read in the same clock: one directed frame pulses `stat_rd` exactly in the Sa8 clock. Several frames are also run with no sync strobe, to check the free-running counter.

// File: rtl/e1sa_pkg.sv
// Shared constants and types for the E1 national bit data link.
// Assumes a timeslot-zero layout with Sa4..Sa8 at zero-based bit positions 3..7.
package e1sa_pkg;
    localparam int SA_NUM   = 5;   // Sa4..Sa8
    localparam int SA_FIRST = 3;   // zero-based position of Sa4 in timeslot zero
    localparam int SEL_W    = 2;   // width of one source select field

    typedef enum logic [SEL_W-1:0] {
        SRC_REG  = 2'd0,
        SRC_HDLC = 2'd1,
        SRC_PIN  = 2'd2,
        SRC_BP   = 2'd3
    } sa_src_e;
endpackage

// File: rtl/e1sa_frame_pos.sv
// Bit position and frame-type tracker for one direction.
// A sync pulse marks position 0 and loads the frame type; without sync
// the counter wraps modulo BITS and the frame type toggles on each wrap.
// The outputs are combinational from the current inputs and the held state.
module e1sa_frame_pos
    import e1sa_pkg::*;
#(
    parameter int BITS = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync,
    input  logic                     nfas_in,
    output logic [$clog2(BITS)-1:0]  pos,
    output logic                     nfas,
    output logic                     sa_win,
    output logic [2:0]               sa_idx
);
    localparam int PW = $clog2(BITS);
    localparam logic [PW-1:0] LAST  = PW'(BITS - 1);
    localparam logic [PW-1:0] FIRST = PW'(SA_FIRST);
    localparam logic [PW-1:0] FINAL = PW'(SA_FIRST + SA_NUM - 1);

    logic [PW-1:0] cnt_q;
    logic          nfas_q;
    logic          wrap;
    logic [PW-1:0] rel;

    // Next position and frame type from sync or from the flywheel.
    always_comb begin
        wrap = (cnt_q == LAST);
        if (sync) begin
            pos  = '0;
            nfas = nfas_in;
        end else begin
            pos  = wrap ? '0 : cnt_q + 1'b1;
            nfas = wrap ? ~nfas_q : nfas_q;
        end
        rel    = pos - FIRST;
        sa_idx = rel[2:0];
        sa_win = nfas && (pos >= FIRST) && (pos <= FINAL);
    end

    // Hold the current position and frame type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= LAST;
            nfas_q <= 1'b1;
        end else begin
            cnt_q  <= pos;
            nfas_q <= nfas;
        end
    end
endmodule

// File: rtl/e1sa_tx_insert.sv
// Transmit Sa inserter. Each Sa position picks its own source. The
// register source is sampled at the start of each odd frame. Output is
// registered: one clock of latency for every bit.
module e1sa_tx_insert
    import e1sa_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      sa_win,
    input  logic [2:0]                sa_idx,
    input  logic [SA_NUM*SEL_W-1:0]   sa_src,
    input  logic                      hdlc_path_sel,
    input  logic [SA_NUM-1:0]         tx_sa_reg,
    input  logic                      tx_in,
    input  logic                      hdlc_tx_bit,
    input  logic                      dl_tx_data,
    input  logic                      bp_tx_bit,
    output logic                      tx_out,
    output logic                      hdlc_tx_req,
    output logic                      dl_tx_clk
);
    logic [SA_NUM-1:0] snap_q;
    logic [SA_NUM-1:0] cand;
    logic [SA_NUM-1:0] use_pin;
    logic [SA_NUM-1:0] use_hdlc;
    logic              cur;

    // Sample the processor register once per odd frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           snap_q <= '0;
        else if (frame_start) snap_q <= tx_sa_reg;
    end

    for (genvar k = 0; k < SA_NUM; k++) begin : g_pos
        sa_src_e sel;
        assign sel = sa_src_e'(sa_src[k*SEL_W +: SEL_W]);
        // Candidate bit for Sa position k from its selected source.
        always_comb begin
            use_pin[k]  = (sel == SRC_PIN);
            use_hdlc[k] = (sel == SRC_HDLC) && !hdlc_path_sel;
            unique case (sel)
                SRC_REG:  cand[k] = snap_q[k];
                SRC_HDLC: cand[k] = hdlc_path_sel ? tx_in : hdlc_tx_bit;
                SRC_PIN:  cand[k] = dl_tx_data;
                SRC_BP:   cand[k] = bp_tx_bit;
                default:  cand[k] = tx_in;
            endcase
        end
    end

    // Choose between the pass-through bit and the Sa candidate; drive strobes.
    always_comb begin
        cur         = sa_win ? cand[sa_idx] : tx_in;
        dl_tx_clk   = sa_win && use_pin[sa_idx];
        hdlc_tx_req = sa_win && use_hdlc[sa_idx];
    end

    // Register the outgoing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_out <= 1'b0;
        else        tx_out <= cur;
    end
endmodule

// File: rtl/e1sa_chg_latch.sv
// Per-bit sticky change flags. On upd, each bit whose new value differs
// from the old one sets (only when armed). clr clears every flag; a set in
// the same clock wins.
module e1sa_chg_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         arm,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] old_val,
    input  logic         clr,
    output logic [W-1:0] lat
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        logic set_k;
        assign set_k = upd && arm && (new_val[k] != old_val[k]);
        // Set on a change, clear on a read, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n) lat[k] <= 1'b0;
            else        lat[k] <= set_k | (lat[k] & ~clr);
        end
    end
endmodule

// File: rtl/e1sa_rx_extract.sv
// Receive Sa extractor. It collects the five Sa bits of each odd frame,
// updates the receive register after Sa8, mirrors each bit onto the serial
// data link pin one clock later, and feeds the change latch.
module e1sa_rx_extract
    import e1sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_win,
    input  logic [2:0]        sa_idx,
    input  logic              rx_in,
    input  logic              stat_rd,
    input  logic [SA_NUM-1:0] irq_mask,
    output logic [SA_NUM-1:0] rx_sa,
    output logic [SA_NUM-1:0] sa_latched,
    output logic              irq,
    output logic              dl_rx_clk,
    output logic              dl_rx_data
);
    logic [SA_NUM-1:0] cap_q;
    logic [SA_NUM-1:0] full;
    logic              done;
    logic              have_prev_q;

    // Merge the bit that is arriving into the bits already collected.
    always_comb begin
        done = sa_win && (sa_idx == 3'(SA_NUM - 1));
        for (int k = 0; k < SA_NUM; k++)
            full[k] = (sa_win && sa_idx == 3'(k)) ? rx_in : cap_q[k];
    end

    // Collect bits, publish the register, and note that a value exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q       <= '0;
            rx_sa       <= '0;
            have_prev_q <= 1'b0;
        end else begin
            if (sa_win) cap_q <= full;
            if (done) begin
                rx_sa       <= full;
                have_prev_q <= 1'b1;
            end
        end
    end

    // Serial data link output, one clock behind each received Sa bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_rx_clk  <= 1'b0;
            dl_rx_data <= 1'b0;
        end else begin
            dl_rx_clk  <= sa_win;
            dl_rx_data <= sa_win && rx_in;
        end
    end

    e1sa_chg_latch #(.W(SA_NUM)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (done),
        .arm     (have_prev_q),
        .new_val (full),
        .old_val (rx_sa),
        .clr     (stat_rd),
        .lat     (sa_latched)
    );

    // Interrupt from any unmasked flag.
    always_comb irq = |(sa_latched & ~irq_mask);
endmodule

// File: rtl/e1_sa_link.sv
// E1 national bit data link top. It tracks the transmit and receive
// frame positions separately and connects the Sa inserter and extractor.
// Assumes the framer gives a sync pulse on bit 1 of timeslot zero.
module e1_sa_link
    import e1sa_pkg::*;
#(
    parameter int BITS_PER_FRAME = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_sync,
    input  logic                    tx_nfas,
    input  logic                    tx_in,
    output logic                    tx_out,
    input  logic [SA_NUM*SEL_W-1:0] sa_src,
    input  logic                    hdlc_path_sel,
    input  logic [SA_NUM-1:0]       tx_sa_reg,
    input  logic                    hdlc_tx_bit,
    output logic                    hdlc_tx_req,
    input  logic                    dl_tx_data,
    output logic                    dl_tx_clk,
    input  logic                    bp_tx_bit,
    input  logic                    rx_sync,
    input  logic                    rx_nfas,
    input  logic                    rx_in,
    output logic [SA_NUM-1:0]       rx_sa,
    output logic [SA_NUM-1:0]       sa_latched,
    input  logic                    stat_rd,
    input  logic [SA_NUM-1:0]       irq_mask,
    output logic                    irq,
    output logic                    dl_rx_clk,
    output logic                    dl_rx_data
);
    localparam int PW = $clog2(BITS_PER_FRAME);

    logic [PW-1:0] tx_pos, rx_pos;
    logic          tx_nf, rx_nf;
    logic          tx_win, rx_win;
    logic [2:0]    tx_idx, rx_idx;
    logic          tx_start;

    e1sa_frame_pos #(.BITS(BITS_PER_FRAME)) u_txpos (
        .clk(clk), .rst_n(rst_n), .sync(tx_sync), .nfas_in(tx_nfas),
        .pos(tx_pos), .nfas(tx_nf), .sa_win(tx_win), .sa_idx(tx_idx)
    );

    e1sa_frame_pos #(.BITS(BITS_PER_FRAME)) u_rxpos (
        .clk(clk), .rst_n(rst_n), .sync(rx_sync), .nfas_in(rx_nfas),
        .pos(rx_pos), .nfas(rx_nf), .sa_win(rx_win), .sa_idx(rx_idx)
    );

    // Start of an odd frame on the transmit side.
    always_comb tx_start = tx_nf && (tx_pos == '0);

    e1sa_tx_insert u_tx (
        .clk(clk), .rst_n(rst_n), .frame_start(tx_start),
        .sa_win(tx_win), .sa_idx(tx_idx), .sa_src(sa_src),
        .hdlc_path_sel(hdlc_path_sel), .tx_sa_reg(tx_sa_reg),
        .tx_in(tx_in), .hdlc_tx_bit(hdlc_tx_bit), .dl_tx_data(dl_tx_data),
        .bp_tx_bit(bp_tx_bit), .tx_out(tx_out),
        .hdlc_tx_req(hdlc_tx_req), .dl_tx_clk(dl_tx_clk)
    );

    e1sa_rx_extract u_rx (
        .clk(clk), .rst_n(rst_n), .sa_win(rx_win), .sa_idx(rx_idx),
        .rx_in(rx_in), .stat_rd(stat_rd), .irq_mask(irq_mask),
        .rx_sa(rx_sa), .sa_latched(sa_latched), .irq(irq),
        .dl_rx_clk(dl_rx_clk), .dl_rx_data(dl_rx_data)
    );
endmodule

// File: rtl/e1_sa_link_chk.sv
// Checker for e1_sa_link, attached by bind. Observes ports only.
module e1_sa_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_out,
    input logic       hdlc_path_sel,
    input logic       hdlc_tx_req,
    input logic       dl_tx_data,
    input logic       dl_tx_clk,
    input logic [4:0] rx_sa,
    input logic [4:0] sa_latched,
    input logic       irq,
    input logic       dl_rx_clk,
    input logic       dl_rx_data
);
    // R5
    pin_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dl_tx_clk |=> (tx_out == $past(dl_tx_data)));

    // R4
    hdlc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdlc_tx_req |-> !hdlc_path_sel);

    // R2
    src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dl_tx_clk && hdlc_tx_req));

    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dl_rx_clk) |-> $stable(rx_sa));

    // R9
    lat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sa_latched & ~$past(sa_latched)) != 5'd0) |-> $past(dl_rx_clk));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_latched == 5'd0) |-> !irq);

    // R8
    rx_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_rx_clk |-> !dl_rx_data);
endmodule

bind e1_sa_link e1_sa_link_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .hdlc_path_sel(hdlc_path_sel),
    .hdlc_tx_req(hdlc_tx_req), .dl_tx_data(dl_tx_data), .dl_tx_clk(dl_tx_clk),
    .rx_sa(rx_sa), .sa_latched(sa_latched), .irq(irq),
    .dl_rx_clk(dl_rx_clk), .dl_rx_data(dl_rx_data)
);

// File: tb/e1_sa_link_bench.sv
module e1_sa_link_bench;
    localparam int BITS = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_sync = 0, tx_nfas = 0, tx_in = 0;
    logic [9:0] sa_src = '0;
    logic hdlc_path_sel = 0;
    logic [4:0] tx_sa_reg = '0;
    logic hdlc_tx_bit = 0, dl_tx_data = 0, bp_tx_bit = 0;
    logic rx_sync = 0, rx_nfas = 0, rx_in = 0;
    logic stat_rd = 0;
    logic [4:0] irq_mask = '0;
    logic tx_out, hdlc_tx_req, dl_tx_clk, irq, dl_rx_clk, dl_rx_data;
    logic [4:0] rx_sa, sa_latched;

    int checks = 0, failures = 0;
    bit done = 0;

    // model state
    logic exp_tx, exp_rclk, exp_rdat;
    string exp_tag;
    bit have_exp = 0;
    logic [4:0] m_snap = '0, m_cap = '0, m_rxsa = '0, m_lat = '0;
    bit m_prev = 0;

    e1_sa_link #(.BITS_PER_FRAME(BITS)) u_e1_sa_link (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] sel_of(input int k);
        return sa_src[2*k +: 2];
    endfunction

    // One bit clock: check previous results, drive new inputs, predict.
    task automatic step(input int p, input bit nfas, input bit sync_en, input bit rd, input bit fly);
        bit win;
        int k;
        string pre;
        pre = fly ? "R11 " : "";
        @(negedge clk);
        if (have_exp) begin
            chk(tx_out === exp_tx, {pre, exp_tag}, tx_out, exp_tx);
            chk(dl_rx_clk === exp_rclk, "R8 clk", dl_rx_clk, exp_rclk);
            chk(dl_rx_data === exp_rdat, "R8 data", dl_rx_data, exp_rdat);
        end
        chk(rx_sa === m_rxsa, "R7 rx_sa", rx_sa, m_rxsa);
        chk(sa_latched === m_lat, "R9 latched", sa_latched, m_lat);
        chk(irq === |(m_lat & ~irq_mask), "R10 irq", irq, |(m_lat & ~irq_mask));

        tx_sync = sync_en; rx_sync = sync_en;
        tx_nfas = nfas;    rx_nfas = nfas;
        tx_in = 1'($urandom); rx_in = 1'($urandom);
        hdlc_tx_bit = 1'($urandom); dl_tx_data = 1'($urandom); bp_tx_bit = 1'($urandom);
        stat_rd = rd;
        if (p == 2) tx_sa_reg = 5'($urandom);  // R3: late write
        if (p == 0 && nfas) m_snap = tx_sa_reg;

        win = nfas && p >= 3 && p <= 7;
        k = p - 3;
        exp_tx = tx_in; exp_tag = "R1 pass";
        if (win) begin
            case (sel_of(k))
                2'd0: begin exp_tx = m_snap[k]; exp_tag = "R2 R3 reg"; end
                2'd1: begin exp_tx = hdlc_path_sel ? tx_in : hdlc_tx_bit; exp_tag = "R4 hdlc"; end
                2'd2: begin exp_tx = dl_tx_data; exp_tag = "R5 pin"; end
                default: begin exp_tx = bp_tx_bit; exp_tag = "R6 bp"; end
            endcase
            m_cap[k] = rx_in;
        end
        if (win && k == 4) begin
            m_lat = (m_lat & ~{5{rd}}) | (m_prev ? (m_rxsa ^ m_cap) : 5'd0);
            m_rxsa = m_cap; m_prev = 1;
        end else if (rd) m_lat = '0;
        exp_rclk = win; exp_rdat = win && rx_in; have_exp = 1;
        #1;
        chk(dl_tx_clk === (win && sel_of(k) == 2'd2), {pre, "R5 dl_tx_clk"}, dl_tx_clk, win && sel_of(k) == 2'd2);
        chk(hdlc_tx_req === (win && sel_of(k) == 2'd1 && !hdlc_path_sel), {pre, "R4 req"}, hdlc_tx_req,
            win && sel_of(k) == 2'd1 && !hdlc_path_sel);
    endtask

    task automatic run_frame(input bit nfas, input bit sync_en, input int rd_pos);
        for (int p = 0; p < BITS; p++)
            step(p, nfas, sync_en && p == 0, p == rd_pos, !sync_en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit nf;
        process::self().srandom(32'd7321);
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(tx_out === 0 && dl_tx_clk === 0 && hdlc_tx_req === 0, "R12 tx", {tx_out, dl_tx_clk, hdlc_tx_req}, 0);
        chk(rx_sa === 0 && sa_latched === 0 && irq === 0, "R12 rx", {rx_sa, sa_latched, irq}, 0);
        chk(dl_rx_clk === 0 && dl_rx_data === 0, "R12 dl_rx", {dl_rx_clk, dl_rx_data}, 0);
        rst_n = 1;
        // directed: first odd frame never sets flags (R9)
        tx_sa_reg = 5'b10110;
        run_frame(0, 1, -1);
        run_frame(1, 1, -1);
        // directed: all pin, then all HDLC with path disabled, then all HDLC enabled
        sa_src = {5{2'd2}}; run_frame(0, 1, -1); run_frame(1, 1, -1);
        sa_src = {5{2'd1}}; hdlc_path_sel = 1; run_frame(0, 1, -1); run_frame(1, 1, -1);
        hdlc_path_sel = 0; run_frame(0, 1, -1); run_frame(1, 1, -1);
        // directed: read in the Sa8 clock, set must win (R9)
        sa_src = {5{2'd3}}; run_frame(0, 1, -1); run_frame(1, 1, 7);
        // random frames with mixed sources, flywheel and reads
        nf = 0;
        for (int f = 0; f < 48; f++) begin
            sa_src = 10'($urandom);
            hdlc_path_sel = ($urandom % 4) == 0;
            irq_mask = 5'($urandom);
            run_frame(nf, (f % 5) != 3, ($urandom % 3 == 0) ? int'($urandom % BITS) : -1);
            nf = !nf;
        end
        @(negedge clk);
        chk(tx_out === exp_tx, exp_tag, tx_out, exp_tx);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule